// File: doc/BRIEF.md
# Floating-Point Sign Manipulation Unit

This block executes the floating-point move-class operations of a 32-bit word-oriented load/store instruction set: absolute value, negation, negative absolute value and plain register copy. It receives one instruction word together with the 64-bit value read from the source register. It decodes the word, rewrites only the sign bit of the binary64 pattern and hands back the result with the destination register index. There is no rounding, no format conversion and no exception signalling. NaN payloads, including the quiet/signalling bit, pass through untouched.

When the instruction's record bit is set, the unit also emits a write of a 4-bit condition field. That field is loaded from four status-summary bits supplied on an input port; it is not derived from a comparison of the result. An instruction word that matches none of the four encodings is flagged as illegal, and every write is held back for it. All outputs are registered one cycle behind an input valid strobe, so one instruction can be issued per clock.

Top module: `fpsign_unit`

## Requirements
- R1: An instruction is recognised only when its primary opcode, in word bits [31:26] (bit 0 of the big-endian numbering is word[31]), equals 63. The 10-bit extended opcode in word[10:1] then selects the operation: 264 is absolute value, 40 is negate, 136 is negative absolute value, and 72 is move.
- R2: Absolute value forces result[63] (the binary64 sign) to 0 and copies result[62:0] from the source unchanged. Thus -0 gives +0, -infinity gives +infinity, and a NaN keeps its exponent, its quiet bit and its payload.
- R3: Negate inverts bit 63 and copies bits [62:0] unchanged.
- R4: Negative absolute value forces bit 63 to 1 and copies bits [62:0] unchanged.
- R5: Move returns the source value bit for bit.
- R6: The destination index output comes from word[25:21]. The combinational source index output comes from word[15:11]. The field in word[20:16] has no effect on any output.
- R7: The record bit is word[0]. When it is 1 on a recognised instruction, cr_wr_en is 1, cr_field is 1 and cr_value equals status_sum. The status_sum bits are ordered {FX, FEX, VX, OX}, with FX in bit 3. When the record bit is 0, cr_wr_en stays 0.
- R8: When in_valid is high and the word matches none of the four encodings, illegal is 1 and both wr_en and cr_wr_en are 0.
- R9: The outputs for an instruction presented with in_valid at clock edge N appear immediately after edge N. Back-to-back instructions each give one result per cycle. After a cycle with in_valid low, out_valid, wr_en, cr_wr_en and illegal are all 0.
- R10: While rst is high, out_valid, wr_en, cr_wr_en, illegal, result and dst_idx are cleared to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand present this cycle |
| instr | input | 32 | Instruction word |
| src_data | input | 64 | Source register value (binary64 pattern) |
| status_sum | input | 4 | Status summary {FX, FEX, VX, OX} |
| src_idx | output | 5 | Source register index, combinational from instr |
| out_valid | output | 1 | Registered outputs hold a result |
| result | output | 64 | Result bit pattern |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register file write enable |
| cr_wr_en | output | 1 | Condition field write enable |
| cr_field | output | 3 | Index of the condition field written (always 1) |
| cr_value | output | 4 | Condition field value |
| illegal | output | 1 | Unrecognised instruction word |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path, a 32-bit instruction word and 5-bit register indices. At those widths the fixed field layout of the word is exercised at its real positions, and the sign bit sits at bit 63. With those values the directed tasks can reach signed zeros, infinities and signalling NaNs with payloads. They also cover every extended-opcode value and near-miss encodings next to it, distinct patterns in each index field, and runs of back-to-back issue with the valid strobe dropping between them.

// File: rtl/fpsign_pkg.sv
package fpsign_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ABS  = 3'd1,
    OP_NEG  = 3'd2,
    OP_NABS = 3'd3,
    OP_MOVE = 3'd4
  } sign_op_e;

  localparam int PRIMARY_OPC = 63;
  localparam int NUM_OPS     = 4;
  localparam int XO_ABS      = 264;
  localparam int XO_NEG      = 40;
  localparam int XO_NABS     = 136;
  localparam int XO_MOVE     = 72;

  function automatic int op_xo(input int k);
    case (k)
      0:       return XO_ABS;
      1:       return XO_NEG;
      2:       return XO_NABS;
      default: return XO_MOVE;
    endcase
  endfunction

  function automatic sign_op_e op_code(input int k);
    case (k)
      0:       return OP_ABS;
      1:       return OP_NEG;
      2:       return OP_NABS;
      default: return OP_MOVE;
    endcase
  endfunction

endpackage

// File: rtl/fpsign_decode.sv
module fpsign_decode
  import fpsign_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OPC_W   = 6,
  parameter int IDX_W   = 5,
  parameter int XO_W    = 10
) (
  input  logic [INSTR_W-1:0] instr,
  output sign_op_e           op,
  output logic               rec,
  output logic [IDX_W-1:0]   dst,
  output logic [IDX_W-1:0]   src
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int DST_LSB = OPC_LSB - IDX_W;
  localparam int SKP_LSB = DST_LSB - IDX_W;
  localparam int SRC_LSB = SKP_LSB - IDX_W;
  localparam int XO_LSB  = 1;

  logic [OPC_W-1:0] opc;
  logic [XO_W-1:0]  xo;
  logic [NUM_OPS-1:0] hit;
  logic unused_skip;

  assign opc = instr[OPC_LSB +: OPC_W];
  assign xo  = instr[XO_LSB +: XO_W];
  assign dst = instr[DST_LSB +: IDX_W];
  assign src = instr[SRC_LSB +: IDX_W];
  assign rec = instr[0];
  assign unused_skip = ^instr[SKP_LSB +: IDX_W];

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_match
    assign hit[k] = (opc == OPC_W'(PRIMARY_OPC)) && (xo == XO_W'(op_xo(k)));
  end

  always_comb begin
    op = OP_NONE;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (hit[k]) op = op_code(k);
    end
  end

endmodule

// File: rtl/fpsign_bitop.sv
module fpsign_bitop
  import fpsign_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  sign_op_e          op,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int SIGN = DATA_W - 1;

  logic sign_new;

  always_comb begin
    case (op)
      OP_ABS:  sign_new = 1'b0;
      OP_NEG:  sign_new = ~din[SIGN];
      OP_NABS: sign_new = 1'b1;
      default: sign_new = din[SIGN];
    endcase
  end

  assign dout = {sign_new, din[SIGN-1:0]};

endmodule

// File: rtl/fpsign_outreg.sv
module fpsign_outreg
  import fpsign_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5,
  parameter int CR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  sign_op_e          op,
  input  logic              rec,
  input  logic [IDX_W-1:0]  dst,
  input  logic [DATA_W-1:0] res,
  input  logic [CR_W-1:0]   status,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dst_idx,
  output logic              wr_en,
  output logic              cr_wr_en,
  output logic [CR_W-1:0]   cr_value,
  output logic              illegal
);

  logic known;
  assign known = (op != OP_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      cr_wr_en  <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
      dst_idx   <= '0;
      cr_value  <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && known;
      cr_wr_en  <= in_valid && known && rec;
      illegal   <= in_valid && !known;
      if (in_valid) begin
        result   <= res;
        dst_idx  <= dst;
        cr_value <= status;
      end
    end
  end

endmodule

// File: rtl/fpsign_unit.sv
module fpsign_unit
  import fpsign_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int INSTR_W  = 32,
  parameter int IDX_W    = 5,
  parameter int CR_W     = 4,
  parameter int CR_IDX_W = 3,
  parameter int CR_FIELD = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   src_data,
  input  logic [CR_W-1:0]     status_sum,
  output logic [IDX_W-1:0]    src_idx,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [IDX_W-1:0]    dst_idx,
  output logic                wr_en,
  output logic                cr_wr_en,
  output logic [CR_IDX_W-1:0] cr_field,
  output logic [CR_W-1:0]     cr_value,
  output logic                illegal
);

  sign_op_e          op;
  logic              rec;
  logic [IDX_W-1:0]  dst;
  logic [DATA_W-1:0] res;

  fpsign_decode #(
    .INSTR_W(INSTR_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .instr(instr),
    .op   (op),
    .rec  (rec),
    .dst  (dst),
    .src  (src_idx)
  );

  fpsign_bitop #(
    .DATA_W(DATA_W)
  ) u_bit (
    .op  (op),
    .din (src_data),
    .dout(res)
  );

  fpsign_outreg #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W),
    .CR_W  (CR_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op       (op),
    .rec      (rec),
    .dst      (dst),
    .res      (res),
    .status   (status_sum),
    .out_valid(out_valid),
    .result   (result),
    .dst_idx  (dst_idx),
    .wr_en    (wr_en),
    .cr_wr_en (cr_wr_en),
    .cr_value (cr_value),
    .illegal  (illegal)
  );

  assign cr_field = CR_IDX_W'(CR_FIELD);

endmodule

// File: rtl/fpsign_unit_chk.sv
module fpsign_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [63:0] src_data,
  input logic [3:0]  status_sum,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        wr_en,
  input logic        cr_wr_en,
  input logic        illegal
);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en && !cr_wr_en && !illegal));

  a_r8_illegal_blocks: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wr_en && !cr_wr_en));

  a_r2_low_bits_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63) |=> (result[62:0] == $past(src_data[62:0])));

  a_r2_abs_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63 && instr[10:1] == 10'd264) |=> !result[63]);

  a_r4_nabs_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63 && instr[10:1] == 10'd136) |=> result[63]);

  a_r7_no_record: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[0]) |=> !cr_wr_en);

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && !cr_wr_en && !illegal));

endmodule

bind fpsign_unit fpsign_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .instr     (instr),
  .src_data  (src_data),
  .status_sum(status_sum),
  .out_valid (out_valid),
  .result    (result),
  .wr_en     (wr_en),
  .cr_wr_en  (cr_wr_en),
  .illegal   (illegal)
);

// File: tb/fpsign_unit_tb.sv
module fpsign_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_data = '0;
  logic [3:0]  status_sum = '0;
  logic [4:0]  src_idx;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  dst_idx;
  logic        wr_en;
  logic        cr_wr_en;
  logic [2:0]  cr_field;
  logic [3:0]  cr_value;
  logic        illegal;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpsign_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_data(src_data), .status_sum(status_sum), .src_idx(src_idx),
    .out_valid(out_valid), .result(result), .dst_idx(dst_idx),
    .wr_en(wr_en), .cr_wr_en(cr_wr_en), .cr_field(cr_field),
    .cr_value(cr_value), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input int opc, input int xo, input int rt,
                                     input int ra, input int rb, input bit rc);
    return {opc[5:0], rt[4:0], ra[4:0], rb[4:0], xo[9:0], rc};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] d, input logic [3:0] s);
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_data = d; status_sum = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 out_valid", 64'(out_valid), 0);
    chk("R10 wr_en", 64'(wr_en), 0);
    chk("R10 cr_wr_en", 64'(cr_wr_en), 0);
    chk("R10 illegal", 64'(illegal), 0);
    chk("R10 result", result, 0);
    chk("R10 dst_idx", 64'(dst_idx), 0);
    rst = 1'b0;
  endtask

  task automatic t_abs;
    issue(mk(63, 264, 3, 0, 4, 0), 64'h8000_0000_0000_0000, 4'h0);
    chk("R2 -0 to +0", result, 64'h0);
    chk("R1 abs wr_en", 64'(wr_en), 1);
    chk("R9 out_valid", 64'(out_valid), 1);
    issue(mk(63, 264, 3, 0, 4, 0), 64'hFFF0_0000_0000_0000, 4'h0);
    chk("R2 -inf", result, 64'h7FF0_0000_0000_0000);
    issue(mk(63, 264, 3, 0, 4, 0), 64'hFFF4_0000_0000_0001, 4'h0);
    chk("R2 sNaN payload", result, 64'h7FF4_0000_0000_0001);
    issue(mk(63, 264, 3, 0, 4, 0), 64'h3FF8_0000_0000_0000, 4'h0);
    chk("R2 positive kept", result, 64'h3FF8_0000_0000_0000);
  endtask

  task automatic t_neg;
    issue(mk(63, 40, 1, 0, 2, 0), 64'h3FF0_0000_0000_0000, 4'h0);
    chk("R3 neg pos", result, 64'hBFF0_0000_0000_0000);
    issue(mk(63, 40, 1, 0, 2, 0), 64'hFFF8_0000_0000_0123, 4'h0);
    chk("R3 neg NaN", result, 64'h7FF8_0000_0000_0123);
  endtask

  task automatic t_nabs;
    issue(mk(63, 136, 1, 0, 2, 0), 64'h4000_0000_0000_0000, 4'h0);
    chk("R4 nabs pos", result, 64'hC000_0000_0000_0000);
    issue(mk(63, 136, 1, 0, 2, 0), 64'hC000_0000_0000_0005, 4'h0);
    chk("R4 nabs neg", result, 64'hC000_0000_0000_0005);
  endtask

  task automatic t_move;
    issue(mk(63, 72, 9, 0, 10, 0), 64'hC123_4567_89AB_CDEF, 4'h0);
    chk("R5 move neg", result, 64'hC123_4567_89AB_CDEF);
    issue(mk(63, 72, 9, 0, 10, 0), 64'h0123_4567_89AB_CDEF, 4'h0);
    chk("R5 move pos", result, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_fields;
    @(negedge clk);
    in_valid = 1'b1; instr = mk(63, 264, 21, 31, 14, 0);
    src_data = 64'hBFF0_0000_0000_0000; status_sum = 4'h0;
    #1 chk("R6 src_idx", 64'(src_idx), 14);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 dst_idx", 64'(dst_idx), 21);
    chk("R6 result with A field set", result, 64'h3FF0_0000_0000_0000);
    issue(mk(63, 264, 21, 0, 14, 0), 64'hBFF0_0000_0000_0000, 4'h0);
    chk("R6 A field ignored", result, 64'h3FF0_0000_0000_0000);
    chk("R6 A field ignored wr_en", 64'(wr_en), 1);
  endtask

  task automatic t_record;
    issue(mk(63, 264, 2, 0, 3, 1), 64'h8000_0000_0000_0001, 4'b1010);
    chk("R7 cr_wr_en", 64'(cr_wr_en), 1);
    chk("R7 cr_value", 64'(cr_value), 64'b1010);
    chk("R7 cr_field", 64'(cr_field), 1);
    issue(mk(63, 72, 2, 0, 3, 1), 64'h1, 4'b0101);
    chk("R7 cr_value move", 64'(cr_value), 64'b0101);
    issue(mk(63, 40, 2, 0, 3, 0), 64'h1, 4'b1111);
    chk("R7 no record", 64'(cr_wr_en), 0);
  endtask

  task automatic t_illegal;
    issue(mk(31, 264, 2, 0, 3, 1), 64'h1, 4'hF);
    chk("R8 wrong primary illegal", 64'(illegal), 1);
    chk("R8 wrong primary wr_en", 64'(wr_en), 0);
    chk("R8 wrong primary cr_wr_en", 64'(cr_wr_en), 0);
    issue(mk(63, 265, 2, 0, 3, 1), 64'h1, 4'hF);
    chk("R8 xo 265 illegal", 64'(illegal), 1);
    chk("R1 xo 265 no write", 64'(wr_en), 0);
    issue(mk(63, 0, 2, 0, 3, 0), 64'h1, 4'hF);
    chk("R8 xo 0 illegal", 64'(illegal), 1);
    issue(mk(63, 264, 2, 0, 3, 0), 64'h1, 4'hF);
    chk("R1 legal not illegal", 64'(illegal), 0);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    in_valid = 1'b1; instr = mk(63, 40, 5, 0, 6, 0); src_data = 64'h1111;
    @(negedge clk);
    chk("R9 b2b first", result, 64'h8000_0000_0000_1111);
    chk("R9 b2b dst first", 64'(dst_idx), 5);
    instr = mk(63, 136, 7, 0, 6, 0); src_data = 64'h2222;
    @(negedge clk);
    chk("R9 b2b second", result, 64'h8000_0000_0000_2222);
    chk("R9 b2b dst second", 64'(dst_idx), 7);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle out_valid", 64'(out_valid), 0);
    chk("R9 idle wr_en", 64'(wr_en), 0);
    chk("R9 idle illegal", 64'(illegal), 0);
  endtask

  initial begin
    t_reset();
    t_abs();
    t_neg();
    t_nabs();
    t_move();
    t_fields();
    t_record();
    t_illegal();
    t_b2b();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule